// File: doc/BRIEF.md
# Decoder Symbol Correction Output Stage

This block is the final stage of a symbol-based error-correcting decoder. For every received symbol, earlier stages supply an error-pattern symbol and a flag that marks a failed decode. The stage flips the marked bits of the received symbol. It sends out the repaired symbol and the pattern that was applied on the same beat. It also keeps a running count of repaired bits for each codeword.

Codewords are delimited by first-beat and last-beat markers. The count starts again on each first beat. On the last beat it appears on the output together with a strobe. A build-time parameter selects the counting style. Full style gives one total. Split style gives two tallies: repaired bits that arrived as 1, and repaired bits that arrived as 0.

Both sides use valid/ready streaming with a ready latency of one cycle. A two-entry skid store between the correction logic and the output holds the beat that can arrive after ready drops, so no beat is lost.

Top module: `rsfix_out_stage`

## Requirements
- R1: On an accepted beat with the fail flag low, the output symbol equals the received symbol XOR the error pattern, bit by bit.
- R2: On the same output beat as the repaired symbol, `out_pattern` carries the pattern that was applied, so XOR of the two output fields gives back the received symbol.
- R3: On a beat with the fail flag high, the received symbol leaves unchanged and `out_pattern` is zero.
- R4: A beat with the fail flag high adds nothing to any bit count.
- R5: The count restarts on a beat with `in_sop` high. The count includes that beat. `cnt_valid` is high exactly on output beats that carry `out_eop`. All count outputs are zero when `cnt_valid` is low.
- R6: In full style (`MODE` = CNT_FULL, value 0), `cnt_total` is the number of 1 bits in the applied patterns of the codeword, and `cnt_ones` and `cnt_zeros` are zero.
- R7: In split style (`MODE` = CNT_SPLIT, value 1), `cnt_ones` counts applied pattern bits whose received bit was 1. `cnt_zeros` counts those whose received bit was 0. `cnt_total` is zero.
- R8: `out_valid` is high in a cycle only if `out_ready` was high in the previous cycle. Every beat shown with `out_valid` high is transferred.
- R9: `in_ready` high in cycle t permits a beat in cycle t+1. Every beat presented with `in_valid` is accepted. Beats leave in arrival order with none lost or repeated, and `in_ready` falls while the output is stalled and the store is full.
- R10: After reset, `out_valid` and `cnt_valid` are low, `in_ready` is high, and the running count is cleared, so a codeword without a first-beat marker counts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat allowed in the next cycle |
| in_sop | input | 1 | First beat of a codeword |
| in_eop | input | 1 | Last beat of a codeword |
| in_fail | input | 1 | Decode failed for this codeword |
| in_data | input | SYM_W | Received symbol |
| in_pattern | input | SYM_W | Error pattern for the symbol |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Output beat allowed in the next cycle |
| out_sop | output | 1 | First beat of a codeword |
| out_eop | output | 1 | Last beat of a codeword |
| out_data | output | SYM_W | Repaired symbol |
| out_pattern | output | SYM_W | Pattern applied to `out_data` |
| cnt_valid | output | 1 | Count outputs hold the codeword result |
| cnt_total | output | CNT_W | Full-style repaired bit count |
| cnt_ones | output | CNT_W | Split-style count, received bit 1 |
| cnt_zeros | output | CNT_W | Split-style count, received bit 0 |

## Verification
The hardest state to reach from the ports is a full skid store. It fills only when the output is held off while the source keeps sending under the one-cycle latency rule. The bench gets there by dropping `out_ready` in long windows during a second pass over the vector table. A directed case then pushes two beats into a fully stalled output and looks for `in_ready` low. Both counting styles are instantiated side by side on the same stimulus. Codewords with a failed last beat, a single beat, or a missing last beat exercise the restart of the count.

// File: rtl/rsfix_pkg.sv
package rsfix_pkg;
  // Counting style for repaired bits
  typedef enum logic {
    CNT_FULL  = 1'b0,
    CNT_SPLIT = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/rsfix_correct.sv
module rsfix_correct
  import rsfix_pkg::*;
#(
  parameter int        SYM_W = 8,
  parameter cnt_mode_e MODE  = CNT_FULL,
  localparam int       WW    = $clog2(SYM_W + 1)
) (
  input  logic [SYM_W-1:0] rx_sym,
  input  logic [SYM_W-1:0] err_pat,
  input  logic             dec_fail,
  output logic [SYM_W-1:0] fix_sym,
  output logic [SYM_W-1:0] used_pat,
  output logic [WW-1:0]    wgt_a,
  output logic [WW-1:0]    wgt_b
);

  // A failed decode gives no trustworthy pattern: pass through untouched
  always_comb begin
    used_pat = dec_fail ? '0 : err_pat;
    fix_sym  = rx_sym ^ used_pat;
  end

  generate
    if (MODE == CNT_SPLIT) begin : g_split
      always_comb begin
        wgt_a = WW'($countones(used_pat & rx_sym));
        wgt_b = WW'($countones(used_pat & ~rx_sym));
      end
    end else begin : g_full
      always_comb begin
        wgt_a = WW'($countones(used_pat));
        wgt_b = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/rsfix_tally.sv
module rsfix_tally #(
  parameter int  SYM_W = 8,
  parameter int  CNT_W = 11,
  localparam int WW    = $clog2(SYM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_vld,
  input  logic             beat_sop,
  input  logic [WW-1:0]    wgt_a,
  input  logic [WW-1:0]    wgt_b,
  output logic [CNT_W-1:0] sum_a,
  output logic [CNT_W-1:0] sum_b
);

  logic [CNT_W-1:0] acc_a_q, acc_b_q;
  logic [CNT_W-1:0] acc_a_d, acc_b_d;
  logic [CNT_W:0]   wide_a, wide_b;

  // Running sum including the current beat; first beat drops history
  always_comb begin
    wide_a  = {1'b0, (beat_sop ? '0 : acc_a_q)} + (CNT_W + 1)'(wgt_a);
    wide_b  = {1'b0, (beat_sop ? '0 : acc_b_q)} + (CNT_W + 1)'(wgt_b);
    sum_a   = wide_a[CNT_W-1:0];
    sum_b   = wide_b[CNT_W-1:0];
    acc_a_d = beat_vld ? sum_a : acc_a_q;
    acc_b_d = beat_vld ? sum_b : acc_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_a_q <= '0;
      acc_b_q <= '0;
    end else begin
      acc_a_q <= acc_a_d;
      acc_b_q <= acc_b_d;
    end
  end

  // R5: count width must hold a full codeword without wrapping
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> (!wide_a[CNT_W] && !wide_b[CNT_W]));

endmodule

// File: rtl/rsfix_skid.sv
module rsfix_skid #(
  parameter int  W     = 32,
  parameter int  DEPTH = 2,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         in_ready,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ordy_q;
  logic          pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    // Latency one: a beat may leave only if the sink was ready last cycle
    pop      = (cnt_q != '0) && ordy_q;
    cnt_d    = cnt_q + CW'(push) - CW'(pop);
    wp_d     = push ? bump(wp_q) : wp_q;
    rp_d     = pop  ? bump(rp_q) : rp_q;
    // Room must remain for a beat arriving next cycle
    in_ready = (cnt_d < CW'(DEPTH));
    out_valid = pop;
    out_data  = mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ordy_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      ordy_q <= out_ready;
    end
  end

  // R9: an arriving beat always finds a free slot
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));

  // R8: nothing is offered in the cycle after the sink withdrew ready
  a_r8_src_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> !out_valid);

endmodule

// File: rtl/rsfix_out_stage.sv
module rsfix_out_stage
  import rsfix_pkg::*;
#(
  parameter int        SYM_W        = 8,
  parameter int        MAX_FIX_BITS = 2040,
  parameter int        DEPTH        = 2,
  parameter cnt_mode_e MODE         = CNT_FULL,
  localparam int       CNT_W        = $clog2(MAX_FIX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             in_fail,
  input  logic [SYM_W-1:0] in_data,
  input  logic [SYM_W-1:0] in_pattern,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sop,
  output logic             out_eop,
  output logic [SYM_W-1:0] out_data,
  output logic [SYM_W-1:0] out_pattern,
  output logic             cnt_valid,
  output logic [CNT_W-1:0] cnt_total,
  output logic [CNT_W-1:0] cnt_ones,
  output logic [CNT_W-1:0] cnt_zeros
);

  localparam int WW = $clog2(SYM_W + 1);
  localparam int EW = 2 + 2 * SYM_W + 2 * CNT_W;

  logic [SYM_W-1:0] fix_sym, used_pat;
  logic [WW-1:0]    wgt_a, wgt_b;
  logic [CNT_W-1:0] sum_a, sum_b;
  logic [EW-1:0]    push_vec, pop_vec;
  logic [CNT_W-1:0] o_a, o_b;

  rsfix_correct #(.SYM_W(SYM_W), .MODE(MODE)) u_corr (
    .rx_sym   (in_data),
    .err_pat  (in_pattern),
    .dec_fail (in_fail),
    .fix_sym  (fix_sym),
    .used_pat (used_pat),
    .wgt_a    (wgt_a),
    .wgt_b    (wgt_b)
  );

  rsfix_tally #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_vld (in_valid),
    .beat_sop (in_sop),
    .wgt_a    (wgt_a),
    .wgt_b    (wgt_b),
    .sum_a    (sum_a),
    .sum_b    (sum_b)
  );

  // Symbol, pattern and counts travel in one entry, so they stay aligned
  assign push_vec = {in_sop, in_eop, fix_sym, used_pat, sum_a, sum_b};

  rsfix_skid #(.W(EW), .DEPTH(DEPTH)) u_skid (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid),
    .push_data (push_vec),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (pop_vec)
  );

  assign {out_sop, out_eop, out_data, out_pattern, o_a, o_b} = pop_vec;
  assign cnt_valid = out_valid & out_eop;

  generate
    if (MODE == CNT_SPLIT) begin : g_out_split
      assign cnt_total = '0;
      assign cnt_ones  = cnt_valid ? o_a : '0;
      assign cnt_zeros = cnt_valid ? o_b : '0;
    end else begin : g_out_full
      assign cnt_total = cnt_valid ? o_a : '0;
      assign cnt_ones  = '0;
      // second tally is held at zero in this style
      assign cnt_zeros = cnt_valid ? o_b : '0;
    end
  endgenerate

  // R3: a failed beat leaves the correction logic untouched
  a_r3_fail_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fail) |-> (fix_sym == in_data && used_pat == '0));

  // R4: a failed beat feeds no weight into the tally
  a_r4_fail_nocount: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_fail) |-> (wgt_a == '0 && wgt_b == '0));

endmodule

// File: tb/test_rsfix_out_stage.sv
`timescale 1ns/1ps
module test_rsfix_out_stage;
  import rsfix_pkg::*;

  localparam int SYM_W = 8;
  localparam int MAXB  = 2040;
  localparam int CW    = $clog2(MAXB + 1);
  localparam int NV    = 10;

  // {sop, eop, fail, data, pattern, expected out_data}
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'hA5, 8'h01, 8'hA4},
    {1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFF},
    {1'b0, 1'b0, 1'b1, 8'h3C, 8'h0F, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'h3C, 8'hF0, 8'hCC},
    {1'b1, 1'b1, 1'b0, 8'h80, 8'h80, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h55, 8'h00, 8'h55},
    {1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 1'b0, 1'b0, 8'h0F, 8'h3C, 8'h33},
    {1'b0, 1'b0, 1'b0, 8'hF0, 8'hAA, 8'h5A},
    {1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sop, in_eop, in_fail, out_ready;
  logic [SYM_W-1:0] in_data, in_pattern;

  logic f_in_ready, f_ov, f_sop, f_eop, f_cv;
  logic [SYM_W-1:0] f_data, f_pat;
  logic [CW-1:0] f_tot, f_one, f_zero;
  logic s_in_ready, s_ov, s_sop, s_eop, s_cv;
  logic [SYM_W-1:0] s_data, s_pat;
  logic [CW-1:0] s_tot, s_one, s_zero;

  always #2.5 clk = ~clk;

  rsfix_out_stage #(.SYM_W(SYM_W), .MAX_FIX_BITS(MAXB), .MODE(CNT_FULL)) i_rsfix_out_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(f_in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_fail(in_fail), .in_data(in_data),
    .in_pattern(in_pattern), .out_valid(f_ov), .out_ready(out_ready),
    .out_sop(f_sop), .out_eop(f_eop), .out_data(f_data), .out_pattern(f_pat),
    .cnt_valid(f_cv), .cnt_total(f_tot), .cnt_ones(f_one), .cnt_zeros(f_zero));

  rsfix_out_stage #(.SYM_W(SYM_W), .MAX_FIX_BITS(MAXB), .MODE(CNT_SPLIT)) i_rsfix_out_stage_sp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(s_in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_fail(in_fail), .in_data(in_data),
    .in_pattern(in_pattern), .out_valid(s_ov), .out_ready(out_ready),
    .out_sop(s_sop), .out_eop(s_eop), .out_data(s_data), .out_pattern(s_pat),
    .cnt_valid(s_cv), .cnt_total(s_tot), .cnt_ones(s_one), .cnt_zeros(s_zero));

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int wr = 0;
  int rd = 0;
  int rt = 0, ro = 0, rz = 0;
  bit rdy_seen = 1'b0;
  bit ordy_prev = 1'b0;
  bit saw_block = 1'b0;
  bit stall = 1'b0;
  bit run_ready = 1'b0;

  logic [SYM_W-1:0] q_data [64];
  logic [SYM_W-1:0] q_pat  [64];
  bit q_sop [64], q_eop [64], q_fail [64];
  int q_t [64], q_o [64], q_z [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Output readiness pattern, changed just after the edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      chk(1'b0, "watchdog", "cycles", cyc, 20000);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = stall ? ((cyc % 8) < 3) : run_ready;
  end

  // Monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (f_ov !== s_ov) chk(1'b0, "R8", "style outputs out of step", s_ov, f_ov);
      if (!f_ov && (f_cv || s_cv)) chk(1'b0, "R5", "cnt_valid without beat", 1, 0);
      if (f_in_ready !== s_in_ready) chk(1'b0, "R9", "in_ready differs", s_in_ready, f_in_ready);
      if (!f_in_ready) saw_block = 1'b1;
      if (f_ov) begin
        chk(ordy_prev, "R8", "out_valid after out_ready low", 1, 0);
        if (rd >= wr) begin
          chk(1'b0, "R9", "unexpected beat", rd, wr);
        end else begin
          chk(f_data == q_data[rd], q_fail[rd] ? "R3" : "R1", "out_data", f_data, q_data[rd]);
          chk(s_data == q_data[rd], q_fail[rd] ? "R3" : "R1", "out_data split", s_data, q_data[rd]);
          chk(f_pat == q_pat[rd], q_fail[rd] ? "R3" : "R2", "out_pattern", f_pat, q_pat[rd]);
          chk(f_sop == q_sop[rd] && f_eop == q_eop[rd], "R9", "order markers",
              {f_sop, f_eop}, {q_sop[rd], q_eop[rd]});
          chk(f_cv == q_eop[rd] && s_cv == q_eop[rd], "R5", "cnt_valid", f_cv, q_eop[rd]);
          chk(f_tot == CW'(q_t[rd]), "R4 R6", "cnt_total full", f_tot, q_t[rd]);
          chk(f_one == '0 && f_zero == '0, "R6", "split counts in full style", {f_one, f_zero}, 0);
          chk(s_one == CW'(q_o[rd]), "R7", "cnt_ones", s_one, q_o[rd]);
          chk(s_zero == CW'(q_z[rd]), "R7", "cnt_zeros", s_zero, q_z[rd]);
          chk(s_tot == '0, "R7", "total in split style", s_tot, 0);
          rd++;
        end
      end
    end
    ordy_prev = out_ready;
    rdy_seen  = f_in_ready;
  end

  task automatic send(input logic [26:0] v);
    logic sp, ep, fl;
    logic [SYM_W-1:0] d, p, ed;
    {sp, ep, fl, d, p, ed} = v;
    forever begin
      @(posedge clk);
      #1;
      if (rdy_seen) break;
      in_valid = 1'b0;
    end
    in_valid = 1'b1; in_sop = sp; in_eop = ep; in_fail = fl;
    in_data = d; in_pattern = p;
    if (sp) begin rt = 0; ro = 0; rz = 0; end
    if (!fl) begin
      rt += $countones(p);
      ro += $countones(p & d);
      rz += $countones(p & ~d);
    end
    q_data[wr] = ed; q_pat[wr] = fl ? '0 : p;
    q_sop[wr] = sp; q_eop[wr] = ep; q_fail[wr] = fl;
    q_t[wr] = ep ? rt : 0; q_o[wr] = ep ? ro : 0; q_z[wr] = ep ? rz : 0;
    wr++;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_fail = 1'b0;
    in_data = '0; in_pattern = '0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R10: state after reset
    chk(f_in_ready && s_in_ready, "R10", "in_ready after reset", f_in_ready, 1);
    chk(!f_ov && !s_ov, "R10", "out_valid after reset", f_ov, 0);
    chk(!f_cv && !s_cv, "R10", "cnt_valid after reset", f_cv, 0);

    // Table pass at full output rate
    run_ready = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < NV; i++) send(VEC[i]);
    idle();
    repeat (8) @(posedge clk);

    // Table pass under stalling output
    stall = 1'b1;
    for (int i = 0; i < NV; i++) send(VEC[i]);
    idle();
    repeat (16) @(posedge clk);
    stall = 1'b0;
    repeat (8) @(posedge clk);
    chk(saw_block, "R9", "in_ready dropped during stall", saw_block, 1);

    // Directed: fill the store with the output held off
    run_ready = 1'b0;
    repeat (3) @(posedge clk);
    send({1'b1, 1'b0, 1'b0, 8'h12, 8'h21, 8'h33});
    send({1'b0, 1'b1, 1'b0, 8'h00, 8'h81, 8'h81});
    idle();
    repeat (3) @(negedge clk);
    chk(!f_ov, "R8", "no beat while output held off", f_ov, 0);
    chk(!f_in_ready, "R9", "in_ready low with store full", f_in_ready, 0);
    run_ready = 1'b1;
    repeat (8) @(posedge clk);
    chk(rd == wr, "R9", "all beats delivered", rd, wr);

    // Directed: reset clears the running count
    send({1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00});
    idle();
    repeat (6) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    rt = 0; ro = 0; rz = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    send({1'b0, 1'b1, 1'b0, 8'h00, 8'h07, 8'h07}); // R10 count from zero
    idle();
    repeat (8) @(posedge clk);
    chk(rd == wr, "R10", "beats after reset delivered", rd, wr);
    finish_run();
  end

endmodule